// File: doc/BRIEF.md
# File Register Execute Unit

This block is the execute stage for a group of single-word instructions that operate on a byte-wide register file in a small accumulator machine. It holds 128 eight-bit file registers, the working register W and the zero flag Z. Each cycle it may receive one decoded operation, given as an operation code, a 7-bit file address, a 3-bit bit index and a destination select. All state changes take effect at the rising clock edge that samples the operation.

The unit handles five operations: complement, decrement, clear of a file register, clear of W, and a bit test that skips when the bit is set. For complement and decrement, the destination select sends the result either to W or back to the addressed file register. When a bit test finds its bit set, the unit raises a skip request to the fetch stage. It then discards the next valid operation it receives, so that operation behaves as a no-operation. No separate read port exists. The contents of a file register are made visible by complementing it into W.

Top module: `fileop_exec`

## Requirements
- R1: After reset, W reads 00h, Z reads 0, skipReq reads 0, and every file register holds 00h.
- R2: Complement (opCode 2) forms the bitwise inverse of the addressed file register. With destSel 0 the result goes to W and the file register is unchanged. With destSel 1 the result goes to the file register and W is unchanged. Z is set if and only if the result is 00h.
- R3: Decrement (opCode 5) forms the addressed register minus one, modulo 256, and uses destSel in the same way as R2. Z is set if and only if the result is 00h. A register holding 00h decrements to FFh with Z cleared.
- R4: Clear-file (opCode 3) writes 00h to the addressed file register and sets Z. W is unchanged and destSel has no effect.
- R5: Clear-W (opCode 4) writes 00h to W and sets Z. No file register changes.
- R6: Bit-test-skip-if-set (opCode 1) reads bit bitSel of the addressed register, where bit 0 is the least significant. If that bit is 1, skipReq is high in the cycle after the test. If it is 0, skipReq stays low. W, Z and the file are not changed.
- R7: While skipReq is high, the next operation presented with opValid is discarded without effect on W, Z or the file, even if it is itself a bit test with the bit set. skipReq is low in the cycle after that operation.
- R8: A cycle with opValid low leaves W, Z, skipReq and the file unchanged. So does an accepted operation with opCode 0 or an undefined code (6 or 7), except that such an operation still consumes a pending skip as in R7.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| opValid | input | 1 | An operation is presented this cycle |
| opCode | input | 3 | Decoded operation: 0 none, 1 bit test skip, 2 complement, 3 clear file, 4 clear W, 5 decrement |
| fileAddr | input | 7 | File register address, 0 to 127 |
| bitSel | input | 3 | Bit index for the bit test |
| destSel | input | 1 | 0 sends the result to W, 1 sends it to the file register |
| wReg | output | 8 | Working register W |
| zFlag | output | 1 | Zero flag |
| skipReq | output | 1 | The next valid operation will be discarded |

## Verification
The assertions assume that reset is held low from time zero and that opValid, opCode and destSel are never unknown while reset is released. The bound properties relate the operation sampled at one edge to W, Z and skipReq after that edge. A driver that changes its inputs between edges therefore keeps every antecedent well defined. The bench holds reset from the start and drives every input at the falling edge. It keeps random addresses within a small window so that operations collide on the same registers, and it lets undefined codes, idle cycles and back-to-back skips appear among the operations.

// File: rtl/fileop_pkg.sv
package fileop_pkg;

  localparam logic [2:0] OP_NONE = 3'd0;
  localparam logic [2:0] OP_BTSS = 3'd1;
  localparam logic [2:0] OP_COMF = 3'd2;
  localparam logic [2:0] OP_CLRF = 3'd3;
  localparam logic [2:0] OP_CLRW = 3'd4;
  localparam logic [2:0] OP_DECF = 3'd5;

  typedef enum logic [1:0] {
    ALU_ZERO = 2'd0,
    ALU_INV  = 2'd1,
    ALU_DEC  = 2'd2
  } aluSel_e;

  typedef struct packed {
    logic    wrFile;
    logic    wrW;
    logic    updZ;
    aluSel_e aluSel;
  } strobe_t;

endpackage

// File: rtl/fileop_ctrl.sv
module fileop_ctrl
  import fileop_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       opValid,
  input  logic [2:0] opCode,
  input  logic       destSel,
  input  logic       testBit,
  output strobe_t    strobe,
  output logic       skipReq
);

  logic skipPend;
  logic accept;
  logic bitSkip;

  // A pending skip swallows the next valid operation.
  assign accept = opValid && !skipPend;

  always_comb begin
    strobe        = '0;
    strobe.aluSel = ALU_ZERO;
    bitSkip       = 1'b0;
    if (accept) begin
      unique case (opCode)
        OP_COMF: begin
          strobe.aluSel = ALU_INV;
          strobe.updZ   = 1'b1;
          strobe.wrW    = !destSel;
          strobe.wrFile = destSel;
        end
        OP_DECF: begin
          strobe.aluSel = ALU_DEC;
          strobe.updZ   = 1'b1;
          strobe.wrW    = !destSel;
          strobe.wrFile = destSel;
        end
        OP_CLRF: begin
          strobe.aluSel = ALU_ZERO;
          strobe.updZ   = 1'b1;
          strobe.wrFile = 1'b1;
        end
        OP_CLRW: begin
          strobe.aluSel = ALU_ZERO;
          strobe.updZ   = 1'b1;
          strobe.wrW    = 1'b1;
        end
        OP_BTSS: begin
          bitSkip = testBit;
        end
        default: begin
          bitSkip = 1'b0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      skipPend <= 1'b0;
    end else if (opValid) begin
      skipPend <= bitSkip;
    end
  end

  assign skipReq = skipPend;

endmodule

// File: rtl/fileop_dpath.sv
module fileop_dpath
  import fileop_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 7,
  localparam int DEPTH = 1 << ADDR_W,
  localparam int BIT_W = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  strobe_t           strobe,
  input  logic [ADDR_W-1:0] fileAddr,
  input  logic [BIT_W-1:0]  bitSel,
  output logic              testBit,
  output logic [DATA_W-1:0] wReg,
  output logic              zFlag
);

  logic [DATA_W-1:0] fileMem [DEPTH];
  logic [DATA_W-1:0] rdVal;
  logic [DATA_W-1:0] result;

  assign rdVal   = fileMem[fileAddr];
  assign testBit = rdVal[bitSel];

  always_comb begin
    unique case (strobe.aluSel)
      ALU_INV: result = ~rdVal;
      ALU_DEC: result = rdVal - DATA_W'(1);
      default: result = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) begin
        fileMem[i] <= '0;
      end
    end else if (strobe.wrFile) begin
      fileMem[fileAddr] <= result;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wReg  <= '0;
      zFlag <= 1'b0;
    end else begin
      if (strobe.wrW) begin
        wReg <= result;
      end
      if (strobe.updZ) begin
        zFlag <= (result == '0);
      end
    end
  end

endmodule

// File: rtl/fileop_exec.sv
module fileop_exec
  import fileop_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 7,
  localparam int BIT_W = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              opValid,
  input  logic [2:0]        opCode,
  input  logic [ADDR_W-1:0] fileAddr,
  input  logic [BIT_W-1:0]  bitSel,
  input  logic              destSel,
  output logic [DATA_W-1:0] wReg,
  output logic              zFlag,
  output logic              skipReq
);

  strobe_t strobe;
  logic    testBit;

  fileop_ctrl u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .opValid (opValid),
    .opCode  (opCode),
    .destSel (destSel),
    .testBit (testBit),
    .strobe  (strobe),
    .skipReq (skipReq)
  );

  fileop_dpath #(
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W)
  ) u_dpath (
    .clk      (clk),
    .rst_n    (rst_n),
    .strobe   (strobe),
    .fileAddr (fileAddr),
    .bitSel   (bitSel),
    .testBit  (testBit),
    .wReg     (wReg),
    .zFlag    (zFlag)
  );

endmodule

// File: rtl/fileop_exec_chk.sv
module fileop_exec_chk
  import fileop_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              opValid,
  input logic [2:0]        opCode,
  input logic              destSel,
  input logic [DATA_W-1:0] wReg,
  input logic              zFlag,
  input logic              skipReq
);

  logic live;
  assign live = opValid && !skipReq;

  AST_CLRW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (live && opCode == OP_CLRW) |=> (wReg == '0 && zFlag)); // R5

  AST_CLRF_KEEPS_W: assert property (@(posedge clk) disable iff (!rst_n)
    (live && opCode == OP_CLRF) |=> (zFlag && $stable(wReg))); // R4

  AST_TEST_NO_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (live && opCode == OP_BTSS) |=> ($stable(zFlag) && $stable(wReg))); // R6

  AST_SKIP_SQUASH: assert property (@(posedge clk) disable iff (!rst_n)
    (opValid && skipReq) |=> (!skipReq && $stable(wReg) && $stable(zFlag))); // R7

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !opValid |=> ($stable(wReg) && $stable(zFlag) && $stable(skipReq))); // R8

  AST_COMF_W_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (live && opCode == OP_COMF && !destSel) |=> (zFlag == (wReg == '0))); // R2

  AST_DECF_W_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (live && opCode == OP_DECF && !destSel) |=> (zFlag == (wReg == '0))); // R3

endmodule

bind fileop_exec fileop_exec_chk #(.DATA_W(DATA_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .opValid (opValid),
  .opCode  (opCode),
  .destSel (destSel),
  .wReg    (wReg),
  .zFlag   (zFlag),
  .skipReq (skipReq)
);

// File: tb/fileop_exec_tb.sv
`timescale 1ns/1ps
module fileop_exec_tb;

  typedef struct {
    logic [7:0] w;
    logic       z;
    logic       skip;
    string      tag;
  } expItem_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       opValid = 1'b0;
  logic [2:0] opCode = 3'd0;
  logic [6:0] fileAddr = 7'd0;
  logic [2:0] bitSel = 3'd0;
  logic       destSel = 1'b0;
  logic [7:0] wReg;
  logic       zFlag;
  logic       skipReq;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  expItem_t   expQ[$];
  logic [7:0] fileM [128];
  logic [7:0] wM = 8'h00;
  logic       zM = 1'b0;
  logic       skipM = 1'b0;

  always #2 clk = ~clk;

  fileop_exec u_dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .opValid  (opValid),
    .opCode   (opCode),
    .fileAddr (fileAddr),
    .bitSel   (bitSel),
    .destSel  (destSel),
    .wReg     (wReg),
    .zFlag    (zFlag),
    .skipReq  (skipReq)
  );

  function automatic string tagFor(input logic v, input logic [2:0] op, input logic sk);
    if (!v) return "R8";
    if (sk) return "R7";
    case (op)
      3'd1: return "R6";
      3'd2: return "R2";
      3'd3: return "R4";
      3'd4: return "R5";
      3'd5: return "R3";
      default: return "R8";
    endcase
  endfunction

  // Driver: presents one cycle of stimulus and queues the expected outcome.
  task automatic step(input logic v, input logic [2:0] op, input logic [6:0] a,
                      input logic [2:0] b, input logic d, input string tag);
    logic [7:0] r;
    expItem_t   e;
    @(negedge clk);
    opValid  = v;
    opCode   = op;
    fileAddr = a;
    bitSel   = b;
    destSel  = d;
    if (v) begin
      if (skipM) begin
        skipM = 1'b0;
      end else begin
        case (op)
          3'd1: skipM = fileM[a][b];
          3'd2, 3'd5: begin
            r = (op == 3'd2) ? ~fileM[a] : fileM[a] - 8'd1;
            if (d) fileM[a] = r; else wM = r;
            zM = (r == 8'h00);
          end
          3'd3: begin fileM[a] = 8'h00; zM = 1'b1; end
          3'd4: begin wM = 8'h00; zM = 1'b1; end
          default: ;
        endcase
      end
    end
    e.w = wM; e.z = zM; e.skip = skipM; e.tag = tag;
    expQ.push_back(e);
  endtask

  task automatic idle(input string tag);
    step(1'b0, 3'd0, 7'd0, 3'd0, 1'b0, tag);
  endtask

  // Monitor: compares each cycle's outputs a little after the edge.
  always @(posedge clk) begin
    #1;
    if (rst_n && expQ.size() > 0) begin
      expItem_t e;
      e = expQ.pop_front();
      total++;
      if (wReg !== e.w || zFlag !== e.z || skipReq !== e.skip) begin
        bad++;
        $display("FAIL %s: w=%h z=%b skip=%b expected w=%h z=%b skip=%b",
                 e.tag, wReg, zFlag, skipReq, e.w, e.z, e.skip);
      end
    end
  end

  initial begin
    #(4 * 100000);
    if (!done) begin
      bad++;
      $display("FAIL R8: watchdog expired actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 128; i++) fileM[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    total++;
    if (wReg !== 8'h00 || zFlag !== 1'b0 || skipReq !== 1'b0) begin
      bad++;
      $display("FAIL R1: w=%h z=%b skip=%b expected w=00 z=0 skip=0", wReg, zFlag, skipReq);
    end
    // R1: file contents read back as FFh through complement into W
    step(1, 3'd2, 7'd0, 0, 0, "R1");
    step(1, 3'd2, 7'd64, 0, 0, "R1");
    step(1, 3'd2, 7'd127, 0, 0, "R1");
    // R5 clear W, R3 wrap from 00h, R2 both destinations
    step(1, 3'd4, 7'd9, 0, 1, "R5");
    step(1, 3'd5, 7'd5, 0, 1, "R3");
    step(1, 3'd2, 7'd5, 0, 0, "R2");
    step(1, 3'd5, 7'd5, 0, 0, "R3");
    step(1, 3'd2, 7'd5, 0, 1, "R2");
    step(1, 3'd2, 7'd5, 0, 0, "R2");
    // R3: 01h decrements to 00h with Z set
    step(1, 3'd5, 7'd127, 0, 1, "R3");
    step(1, 3'd5, 7'd127, 0, 1, "R3");
    step(1, 3'd2, 7'd127, 0, 1, "R2");
    step(1, 3'd5, 7'd127, 0, 1, "R3");
    step(1, 3'd2, 7'd127, 0, 0, "R3");
    // R4: clear file with either destSel, W kept
    step(1, 3'd5, 7'd20, 0, 0, "R3");
    step(1, 3'd3, 7'd5, 0, 0, "R4");
    step(1, 3'd3, 7'd127, 0, 1, "R4");
    step(1, 3'd2, 7'd127, 0, 0, "R4");
    // R6/R7: register 10 holds 01h
    step(1, 3'd5, 7'd10, 0, 1, "R3");
    step(1, 3'd5, 7'd10, 0, 1, "R3");
    step(1, 3'd2, 7'd10, 0, 1, "R2");
    step(1, 3'd1, 7'd10, 3'd0, 0, "R6");
    step(1, 3'd4, 7'd0, 0, 0, "R7");
    step(1, 3'd1, 7'd10, 3'd1, 0, "R6");
    step(1, 3'd1, 7'd10, 3'd0, 0, "R6");
    idle("R8");
    idle("R8");
    step(1, 3'd3, 7'd10, 0, 0, "R7");
    step(1, 3'd2, 7'd10, 0, 0, "R7");
    // R7: a squashed test with its bit set raises no new skip
    step(1, 3'd1, 7'd10, 3'd0, 0, "R6");
    step(1, 3'd1, 7'd10, 3'd0, 0, "R7");
    step(1, 3'd4, 7'd0, 0, 0, "R7");
    // R6: bit 7 of a register holding FFh
    step(1, 3'd5, 7'd30, 0, 1, "R3");
    step(1, 3'd1, 7'd30, 3'd7, 0, "R6");
    step(1, 3'd0, 7'd30, 0, 0, "R8");
    // R8: codes 0, 6, 7 change nothing
    step(1, 3'd2, 7'd30, 0, 0, "R2");
    step(1, 3'd6, 7'd30, 0, 1, "R8");
    step(1, 3'd7, 7'd30, 0, 1, "R8");
    step(1, 3'd0, 7'd30, 0, 1, "R8");
    step(1, 3'd2, 7'd30, 0, 0, "R8");
    // mixed random traffic on a small address window
    for (int n = 0; n < 400; n++) begin
      logic       v;
      logic [2:0] op;
      v  = ($urandom_range(0, 7) != 0);
      op = 3'($urandom_range(0, 7));
      step(v, op, 7'($urandom_range(122, 127)), 3'($urandom_range(0, 7)),
           1'($urandom_range(0, 1)), tagFor(v, op, skipM));
    end
    idle("R8");
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule